// File: doc/BRIEF.md
# Multi-Mode Reloadable Wakeup Timer

A 32-bit timer that counts prescaled clock ticks or edges of an external input and compares the count against a programmable limit. It sits behind a plain word-addressed register port. The port has an address, a write strobe, write data and combinational read data. It drives a single level interrupt line.

A 3-bit mode field selects one of seven behaviours:

- **Interval modes:** one-shot and auto-repeat.
- **Counting modes:** external event counting and gated counting.
- **Capture and compare modes:** capture, free-running compare, and capture-with-compare.

A 4-bit power-of-two divide code sets the prescaler. Three of its bits sit in one control field and the fourth sits in a separate, higher control bit.

A polarity bit chooses which level of the timer input counts as active. Software arms the timer by setting the enable bit. It acknowledges the interrupt by writing any value to the interrupt word.

Top module: `wake_timer`

## Requirements
- R1: Word index (address bits [5:2]) selects the register:
  - 0 is the count.
  - 1 is the compare limit.
  - 3 is the interrupt word, where bit 0 reads the pending flag.
  - 4 is the control word, 9 bits.
  - 5 is the paired 8-bit limit word, 16 bits, stored and read back only.
  - 6 and 7 are two plain 32-bit storage words.
  - 8 is the snapshot, which is read-only.
  - Index 2 and any unmapped index read as zero, and unused high bits read as zero.
- R2: Control bits [5:3] together with bit 8 as the top bit form a code n. While enabled (control bit 7), the timer advances once every 2^n clocks. The prescaler restarts from zero each time the enable bit is set.
- R3: In auto-repeat mode (control [2:0] = 1), an advance taken while the count equals the compare limit has these effects:
  - It loads the count with 1 instead of incrementing.
  - It sets the pending flag.
  - The timer keeps running.
- R4: In one-shot mode (code 0), a compare match loads the count with 1, sets the pending flag and clears the enable bit. Afterwards the count holds.
- R5: In event-count mode (code 2), the count advances once per active edge of the timer input and ignores prescaler ticks. Polarity bit 6 set to 0 makes a rising edge active. Set to 1, it makes a falling edge active.
- R6: In gated mode (code 6), the count advances on prescaler ticks only while the synchronised input is at its active level.
- R7: In capture mode (code 4), an active input edge has these effects:
  - It copies the count into the snapshot.
  - It sets the pending flag.
  - It loads the count with 1.
- R8: In compare mode (code 5), a match sets the pending flag and the count keeps incrementing past the limit.
- R9: In capture-compare mode (code 7):
  - An active edge copies the count into the snapshot and sets the pending flag without disturbing the count.
  - A compare match reloads the count to 1 without setting the flag.
- R10: Any write to the interrupt word clears the pending flag, unless a new event arrives on the same edge, in which case the flag stays set. The irq output is high exactly while the flag is set.
- R11: A register write to the count takes priority over an advance or reload in the same cycle.
- R12: With the enable bit clear, or with the unused mode code 3, the count holds.
- R13: After reset every register and the irq output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address of the register word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tmr_in | input | 1 | External timer input |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The hardest situation to reach is a clear of the interrupt word landing on the same clock edge as a compare match. The stimulus arms auto-repeat mode with divide-by-one from a known count. It then counts clock edges exactly so that the clear write lands on the matching edge. Input-driven modes depend on a two-stage input synchroniser. The bench therefore times input pulses from the falling clock edge and predicts the advance two rising edges later.

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int AW  = 6,
  parameter int DW  = 32,
  parameter int NW  = 16,
  parameter int PCW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmr_in,
  output logic          irq
);
  localparam int IW = AW - 2;
  localparam int PW = (1 << PCW) - 1;

  localparam logic [IW-1:0] IX_CNT = 0, IX_CMP = 1, IX_INT = 3, IX_CTL = 4,
                            IX_NOL = 5, IX_PST = 6, IX_RLD = 7, IX_SNP = 8;
  localparam logic [2:0] M_ONE = 3'd0, M_RPT = 3'd1, M_EVT = 3'd2, M_CAP = 3'd4,
                         M_CMP = 3'd5, M_GAT = 3'd6, M_CCM = 3'd7;

  logic [DW-1:0] cnt_q, cmp_q, pst_q, rld_q, snp_q, cnt_d;
  logic [NW-1:0] nol_q;
  logic [8:0]    ctl_q;
  logic [PW-1:0] pre_q, pre_lim;
  logic          pend_q, s1_q, s2_q;
  logic          adv, hit, cap, stop, tick, act, edge_a;

  wire [IW-1:0] idx  = bus_addr[AW-1:2];
  wire [2:0]    mode = ctl_q[2:0];
  wire          pol  = ctl_q[6];
  wire          en   = ctl_q[7];
  wire [PCW-1:0] pcode = {ctl_q[8], ctl_q[5:3]};
  wire          wr_cnt = bus_we && idx == IX_CNT;
  wire          wr_int = bus_we && idx == IX_INT;
  wire          wr_ctl = bus_we && idx == IX_CTL;
  wire          set_pend = hit | cap;

  assign pre_lim = PW'((32'd1 << pcode) - 32'd1);
  assign tick    = en && pre_q == pre_lim;
  assign act     = s1_q ^ pol;
  assign edge_a  = act && !(s2_q ^ pol);
  assign irq     = pend_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= tmr_in;
      s2_q <= s1_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pre_q <= '0;
    else if (!en || tick) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    cap   = 1'b0;
    stop  = 1'b0;
    case (mode)
      M_EVT:   adv = edge_a;
      M_GAT:   adv = tick && act;
      3'd3:    adv = 1'b0;
      default: adv = tick;
    endcase
    if (en) begin
      if (adv) begin
        if (cnt_q == cmp_q && mode != M_CAP && mode != M_CMP) cnt_d = 1;
        else cnt_d = cnt_q + 1'b1;
        hit = cnt_q == cmp_q && mode != M_CAP && mode != M_CCM;
      end
      if (edge_a && (mode == M_CAP || mode == M_CCM)) begin
        cap = 1'b1;
        if (mode == M_CAP) cnt_d = 1;
      end
      stop = hit && mode == M_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0; cmp_q <= '0; pst_q <= '0; rld_q <= '0;
      snp_q <= '0; nol_q <= '0; ctl_q <= '0; pend_q <= 1'b0;
    end else begin
      cnt_q <= wr_cnt ? bus_wdata : cnt_d;
      if (bus_we && idx == IX_CMP) cmp_q <= bus_wdata;
      if (bus_we && idx == IX_NOL) nol_q <= bus_wdata[NW-1:0];
      if (bus_we && idx == IX_PST) pst_q <= bus_wdata;
      if (bus_we && idx == IX_RLD) rld_q <= bus_wdata;
      if (cap) snp_q <= cnt_q;
      if (wr_ctl)    ctl_q <= bus_wdata[8:0];
      else if (stop) ctl_q[7] <= 1'b0;
      if (set_pend)    pend_q <= 1'b1;
      else if (wr_int) pend_q <= 1'b0;
    end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IX_CNT:  bus_rdata = cnt_q;
      IX_CMP:  bus_rdata = cmp_q;
      IX_INT:  bus_rdata[0] = pend_q;
      IX_CTL:  bus_rdata[8:0] = ctl_q;
      IX_NOL:  bus_rdata[NW-1:0] = nol_q;
      IX_PST:  bus_rdata = pst_q;
      IX_RLD:  bus_rdata = rld_q;
      IX_SNP:  bus_rdata = snp_q;
      default: bus_rdata = '0;
    endcase
  end

  // R11
  cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr[AW-1:2] == IX_CNT |=> cnt_q == $past(bus_wdata));

  // R12
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[7] || ctl_q[2:0] == 3'd3) && !(bus_we && bus_addr[AW-1:2] == IX_CNT) |=> $stable(cnt_q));

  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7] && ctl_q[2:0] == M_ONE && tick && cnt_q == cmp_q && !bus_we |=> !ctl_q[7] && cnt_q == 1 && irq);

  // R7
  capture_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7] && ctl_q[2:0] == M_CAP && edge_a && !bus_we |=> snp_q == $past(cnt_q) && cnt_q == 1 && irq);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr[AW-1:2] == IX_INT && !hit && !cap |=> !irq);

  // R2
  presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[7] |=> pre_q == '0);
endmodule

// File: tb/wake_timer_tb.sv
module wake_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tmr_in = 1'b0;
  logic        irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  wake_timer u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_in(tmr_in), .irq(irq));

  localparam logic [5:0] A_CNT = 6'h00, A_CMP = 6'h04, A_RSV = 6'h08, A_INT = 6'h0C,
                         A_CTL = 6'h10, A_NOL = 6'h14, A_PST = 6'h18, A_RLD = 6'h1C,
                         A_SNP = 6'h20;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] cmp);
    wr(A_CTL, 0); wr(A_CNT, 0); wr(A_INT, 0); wr(A_CMP, cmp);
  endtask

  task automatic pulse();
    tmr_in = ~tmr_in; cyc(2);
    tmr_in = ~tmr_in; cyc(2);
  endtask

  task automatic t_reset();
    rdchk("R13 count", A_CNT, 0);
    rdchk("R13 ctrl", A_CTL, 0);
    rdchk("R13 snap", A_SNP, 0);
    rdchk("R13 int", A_INT, 0);
    chk("R13 irq", irq, 0);
  endtask

  task automatic t_regs();
    wr(A_CMP, 32'hDEAD_BEEF); rdchk("R1 cmp", A_CMP, 32'hDEAD_BEEF);
    wr(A_NOL, 32'hFFFF_FFFF); rdchk("R1 nol", A_NOL, 32'h0000_FFFF);
    wr(A_PST, 32'h1234_5678); rdchk("R1 preset", A_PST, 32'h1234_5678);
    wr(A_RLD, 32'h8765_4321); rdchk("R1 reload", A_RLD, 32'h8765_4321);
    wr(A_CTL, 32'hFFFF_FF7F); rdchk("R1 ctrl", A_CTL, 32'h0000_017F);
    wr(A_CTL, 0);
    wr(A_RSV, 32'hFFFF_FFFF); rdchk("R1 reserved", A_RSV, 0);
    wr(A_SNP, 32'h5555_5555); rdchk("R1 snapshot ro", A_SNP, 0);
    rdchk("R1 unmapped", 6'h24, 0);
  endtask

  task automatic t_presc();
    setup(1000);
    wr(A_CTL, 32'h80 | (2 << 3) | 1);
    cyc(7); rdchk("R2 div4 k7", A_CNT, 1);
    cyc(1); rdchk("R2 div4 k8", A_CNT, 2);
    cyc(2);
    wr(A_CTL, (2 << 3) | 1);
    rdchk("R2 div4 hold", A_CNT, 2);
    wr(A_CTL, 32'h80 | (2 << 3) | 1);
    cyc(3); rdchk("R2 restart k3", A_CNT, 2);
    cyc(1); rdchk("R2 restart k4", A_CNT, 3);
    setup(1000);
    wr(A_CTL, 32'h180 | 1);
    cyc(255); rdchk("R2 div256 k255", A_CNT, 0);
    cyc(1);   rdchk("R2 div256 k256", A_CNT, 1);
  endtask

  task automatic t_repeat();
    setup(3);
    wr(A_CTL, 32'h81);
    cyc(3); rdchk("R3 before match", A_CNT, 3); chk("R3 irq low", irq, 0);
    cyc(1); rdchk("R3 reload 1", A_CNT, 1); chk("R3 irq set", irq, 1);
    cyc(1); rdchk("R3 runs on", A_CNT, 2);
  endtask

  task automatic t_oneshot();
    setup(2);
    wr(A_CTL, 32'h80);
    cyc(3);
    rdchk("R4 count 1", A_CNT, 1);
    rdchk("R4 enable cleared", A_CTL, 0);
    chk("R4 irq", irq, 1);
    cyc(4); rdchk("R4 holds", A_CNT, 1);
  endtask

  task automatic t_clear();
    setup(3);
    wr(A_CTL, 32'h81);
    cyc(3);
    wr(A_INT, 0);
    chk("R10 set wins", irq, 1);
    rdchk("R10 int word", A_INT, 1);
    wr(A_CTL, 0);
    wr(A_INT, 32'hFFFF_FFFE);
    chk("R10 cleared", irq, 0);
  endtask

  task automatic t_event();
    setup(1000);
    wr(A_CTL, 32'h82);
    cyc(5); rdchk("R5 ticks ignored", A_CNT, 0);
    pulse(); pulse(); pulse();
    rdchk("R5 rising edges", A_CNT, 3);
    wr(A_CTL, 32'hC2);
    tmr_in = 1'b1; cyc(3);
    rdchk("R5 rise inactive", A_CNT, 3);
    tmr_in = 1'b0; cyc(3);
    rdchk("R5 falling edge", A_CNT, 4);
    tmr_in = 1'b0;
  endtask

  task automatic t_gated();
    setup(1000);
    wr(A_CTL, 32'h86);
    cyc(5); rdchk("R6 gate closed", A_CNT, 0);
    tmr_in = 1'b1; cyc(6);
    tmr_in = 1'b0; cyc(4);
    rdchk("R6 gated count", A_CNT, 6);
  endtask

  task automatic t_capture();
    setup(5);
    wr(A_CTL, 32'h84);
    cyc(10); rdchk("R7 free count", A_CNT, 10);
    tmr_in = 1'b1; cyc(2);
    rdchk("R7 snapshot", A_SNP, 11);
    rdchk("R7 count 1", A_CNT, 1);
    chk("R7 irq", irq, 1);
    tmr_in = 1'b0; cyc(2);
  endtask

  task automatic t_compare();
    setup(3);
    wr(A_CTL, 32'h85);
    cyc(5);
    rdchk("R8 past limit", A_CNT, 5);
    chk("R8 irq", irq, 1);
  endtask

  task automatic t_capcmp();
    setup(3);
    wr(A_CTL, 32'h87);
    cyc(5);
    rdchk("R9 silent reload", A_CNT, 2);
    chk("R9 no irq", irq, 0);
    setup(1000);
    wr(A_CTL, 32'h87);
    cyc(6);
    tmr_in = 1'b1; cyc(2);
    rdchk("R9 snapshot", A_SNP, 7);
    rdchk("R9 count kept", A_CNT, 8);
    chk("R9 irq", irq, 1);
    tmr_in = 1'b0; cyc(2);
  endtask

  task automatic t_wpri();
    setup(1000);
    wr(A_CTL, 32'h81);
    cyc(4);
    wr(A_CNT, 50);
    rdchk("R11 write wins", A_CNT, 50);
    cyc(1); rdchk("R11 then advance", A_CNT, 51);
  endtask

  task automatic t_hold();
    setup(1000);
    wr(A_CNT, 7);
    wr(A_CTL, 32'h83);
    cyc(5); rdchk("R12 mode3 holds", A_CNT, 7);
    wr(A_CTL, 32'h01);
    cyc(5); rdchk("R12 disabled holds", A_CNT, 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_regs();
    t_presc();
    t_repeat();
    t_oneshot();
    t_clear();
    t_event();
    t_gated();
    t_capture();
    t_compare();
    t_capcmp();
    t_wpri();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule